// File: doc/BRIEF.md
# PS/2 Channel Register Interface

This block sits between a processor bus and one PS/2-style keyboard or mouse channel. It decodes a 4 KB register window and exposes five registers: control, status, data, clock divisor and interrupt status. It also exposes a read-only area of eight identification words near the top of the window. Serial bit shifting and line timing belong to a separate engine. That engine hands received bytes in through a valid/ready pair and takes bytes written by the processor through a one-cycle transmit strobe.

One received byte can wait in a holding slot. A read of the data register pops that byte and latches it as the "last byte". The receive parity status bit is always computed from that latched byte. A read with nothing waiting returns the last byte again. A single level interrupt combines a receive-pending term, gated by a control bit, with a second control bit that raises the line unconditionally. The clock divisor is plain storage.

Top module: `ps2PortRegs`

## Requirements
- R1: After reset the control, divisor and last-byte registers are zero and no byte is pending. `irq` is low, `rxReady` is high and `txStrobe` is low.
- R2: The register index is `busAddr[11:2]`, so address bits [1:0] are ignored. Index 0 is control, 1 status, 2 data, 3 divisor and 4 interrupt status. Read data appears on `busRdata` in the cycle after the access.
- R3: The status word reads bit6 = 1 always (transmit empty), bit4 = byte pending, bit2 = parity. Bits 5, 3, 1 and 0 read 0.
- R4: The parity bit equals the XOR of all 8 bits of the last latched byte. It ignores any byte still pending.
- R5: A data read while a byte is pending returns that byte, latches it as the last byte and clears pending. A data read with nothing pending returns the last byte unchanged.
- R6: `rxReady` is high only while no byte is pending. A byte offered while one is pending is not taken, and the held byte is kept.
- R7: `irq` = (control bit4 AND pending) OR control bit3. It follows register changes in the cycle after the edge that updates them.
- R8: The interrupt-status register reads pending in bit0 and 1 in bit1. All other bits read 0.
- R9: Byte addresses 0xFE0 to 0xFFC read the identification bytes 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, one per word in that order.
- R10: A write to the data register raises `txStrobe` for exactly one cycle after the write, with `txByte` = `busWdata[7:0]`. No other write raises it.
- R11: The divisor register stores and returns the full bus word and has no other effect.
- R12: Reads of undefined addresses return 0. Writes to undefined addresses, to status, to interrupt status and to the identification area change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Single-cycle bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| rxValid | input | 1 | Received byte offered |
| rxByte | input | 8 | Received byte |
| rxReady | output | 1 | Holding slot empty |
| txStrobe | output | 1 | One-cycle transmit request |
| txByte | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the mismatch between the parity bit and the byte that is waiting. Parity reflects the previously popped byte, not the byte the status register reports as pending. The bench reaches this case by popping a byte of even parity, offering one of odd parity, and reading status before and after the next pop. It also offers a second byte while one is held, to show that the handshake stalls and that the held byte survives.

// File: rtl/ps2PortPkg.sv
package ps2PortPkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_DATA,
    SEL_DIV,
    SEL_ISTAT,
    SEL_ID
  } regSel_e;

  typedef struct packed {
    logic    rdEn;
    regSel_e sel;
    logic [2:0] idWord;
    logic    wrCtrl;
    logic    wrDiv;
    logic    wrData;
    logic    rdData;
  } busStrobes_t;

  localparam int IRQ_RX_BIT  = 4;
  localparam int IRQ_ALL_BIT = 3;

  function automatic logic [7:0] idValue(input logic [2:0] word);
    logic [7:0] v;
    case (word)
      3'd0: v = 8'h50;
      3'd1: v = 8'h10;
      3'd2: v = 8'h04;
      3'd3: v = 8'h00;
      3'd4: v = 8'h0D;
      3'd5: v = 8'hF0;
      3'd6: v = 8'h05;
      default: v = 8'hB1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ps2PortCtrl.sv
module ps2PortCtrl
  import ps2PortPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ID_BASE = 12'hFE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobes_t       strb
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_CTRL  = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_STAT  = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_DATA  = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_DIV   = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_ISTAT = IDX_W'(4);

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] idOffset;
  logic              idHit;

  assign idx      = busAddr[ADDR_W-1:2];
  assign idHit    = (busAddr >= ID_BASE);
  assign idOffset = busAddr - ID_BASE;

  always_comb begin
    strb        = '0;
    strb.sel    = SEL_NONE;
    strb.idWord = idOffset[4:2];
    if (busValid) begin
      strb.rdEn = !busWrite;
      if (idHit) begin
        strb.sel = SEL_ID;
      end else begin
        case (idx)
          I_CTRL: begin
            strb.sel    = SEL_CTRL;
            strb.wrCtrl = busWrite;
          end
          I_STAT:  strb.sel = SEL_STAT;
          I_DATA: begin
            strb.sel    = SEL_DATA;
            strb.wrData = busWrite;
            strb.rdData = !busWrite;
          end
          I_DIV: begin
            strb.sel   = SEL_DIV;
            strb.wrDiv = busWrite;
          end
          I_ISTAT: strb.sel = SEL_ISTAT;
          default: strb.sel = SEL_NONE;
        endcase
      end
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrl, strb.wrDiv, strb.wrData, strb.rdData})) else $error("strobe clash"); // R2

  AST_ID_READONLY: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr >= ID_BASE) |-> !(strb.wrCtrl || strb.wrDiv || strb.wrData)) else $error("id write"); // R12

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (strb.sel == SEL_NONE) && !strb.rdEn) else $error("idle strobe"); // R12

endmodule

// File: rtl/ps2PortDatapath.sv
module ps2PortDatapath
  import ps2PortPkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strb,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              rxReady,
  output logic              txStrobe,
  output logic [BYTE_W-1:0] txByte,
  output logic              irq
);

  localparam int STAT_W = 7;

  logic [BUS_W-1:0]  ctrlReg;
  logic [BUS_W-1:0]  divReg;
  logic [BYTE_W-1:0] lastByte;
  logic [BYTE_W-1:0] holdByte;
  logic              pending;
  logic              parityBit;
  logic              popNow;
  logic              rxTake;
  logic [STAT_W-1:0] statWord;
  logic [BUS_W-1:0]  rdNext;

  assign rxReady   = !pending;
  assign rxTake    = rxValid && rxReady;
  assign popNow    = strb.rdData && pending;
  assign parityBit = ^lastByte;
  assign statWord  = {1'b1, 1'b0, pending, 1'b0, parityBit, 2'b00};
  assign irq       = (ctrlReg[IRQ_RX_BIT] && pending) || ctrlReg[IRQ_ALL_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      divReg  <= '0;
    end else begin
      if (strb.wrCtrl) ctrlReg <= busWdata;
      if (strb.wrDiv)  divReg  <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      holdByte <= '0;
      lastByte <= '0;
    end else begin
      if (popNow) begin
        lastByte <= holdByte;
        pending  <= 1'b0;
      end else if (rxTake) begin
        holdByte <= rxByte;
        pending  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txStrobe <= 1'b0;
      txByte   <= '0;
    end else begin
      txStrobe <= strb.wrData;
      if (strb.wrData) txByte <= busWdata[BYTE_W-1:0];
    end
  end

  always_comb begin
    case (strb.sel)
      SEL_CTRL:  rdNext = ctrlReg;
      SEL_STAT:  rdNext = BUS_W'(statWord);
      SEL_DATA:  rdNext = BUS_W'(pending ? holdByte : lastByte);
      SEL_DIV:   rdNext = divReg;
      SEL_ISTAT: rdNext = BUS_W'({1'b1, pending});
      SEL_ID:    rdNext = BUS_W'(idValue(strb.idWord));
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else if (strb.rdEn) busRdata <= rdNext;
  end

  AST_RX_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady) |=> pending) else $error("rx not taken"); // R6

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !strb.rdData) |=> (pending && $stable(holdByte))) else $error("held byte lost"); // R6

  AST_POP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdData && pending) |=> (!pending && lastByte == $past(holdByte))) else $error("pop failed"); // R5

  AST_LAST_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdData && pending) |=> $stable(lastByte)) else $error("last byte moved"); // R5

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |-> $past(strb.wrData)) else $error("stray tx"); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!pending && !ctrlReg[IRQ_ALL_BIT]) |-> !irq) else $error("stray irq"); // R7

endmodule

// File: rtl/ps2PortRegs.sv
module ps2PortRegs
  import ps2PortPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] ID_BASE = 12'hFE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              rxReady,
  output logic              txStrobe,
  output logic [BYTE_W-1:0] txByte,
  output logic              irq
);

  busStrobes_t strb;

  ps2PortCtrl #(
    .ADDR_W (ADDR_W),
    .ID_BASE(ID_BASE)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strb    (strb)
  );

  ps2PortDatapath #(
    .BUS_W (BUS_W),
    .BYTE_W(BYTE_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .rxValid (rxValid),
    .rxByte  (rxByte),
    .rxReady (rxReady),
    .txStrobe(txStrobe),
    .txByte  (txByte),
    .irq     (irq)
  );

endmodule

// File: tb/tb_ps2PortRegs.sv
`timescale 1ns/1ps
module tb_ps2PortRegs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxReady;
  logic        txStrobe;
  logic [7:0]  txByte;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic txSeen;
  logic [31:0] rd;

  always #10 clk = ~clk;

  ps2PortRegs dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxValid(rxValid), .rxByte(rxByte), .rxReady(rxReady),
    .txStrobe(txStrobe), .txByte(txByte), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h000, 32'h0,       32'h0,       4'd1},  // R1 control zero
    '{1'b0, 12'h00C, 32'h0,       32'h0,       4'd1},  // R1 divisor zero
    '{1'b0, 12'h004, 32'h0,       32'h40,      4'd3},  // R3 idle status
    '{1'b0, 12'h010, 32'h0,       32'h02,      4'd8},  // R8 idle istat
    '{1'b0, 12'h008, 32'h0,       32'h0,       4'd1},  // R1 last byte zero
    '{1'b1, 12'h00C, 32'hDEADA5C3,32'h0,       4'd11},
    '{1'b0, 12'h00C, 32'h0,       32'hDEADA5C3,4'd11}, // R11
    '{1'b1, 12'h000, 32'h10,      32'h0,       4'd2},
    '{1'b0, 12'h000, 32'h0,       32'h10,      4'd2},  // R2
    '{1'b0, 12'h00E, 32'h0,       32'hDEADA5C3,4'd2},  // R2 low bits ignored
    '{1'b1, 12'h014, 32'hFFFF,    32'h0,       4'd12},
    '{1'b0, 12'h014, 32'h0,       32'h0,       4'd12}, // R12
    '{1'b0, 12'h000, 32'h0,       32'h10,      4'd12}, // R12
    '{1'b1, 12'h004, 32'hFF,      32'h0,       4'd12},
    '{1'b1, 12'h010, 32'hFF,      32'h0,       4'd12},
    '{1'b0, 12'h004, 32'h0,       32'h40,      4'd12}, // R12
    '{1'b0, 12'h010, 32'h0,       32'h02,      4'd12}, // R12
    '{1'b1, 12'hFE0, 32'h77,      32'h0,       4'd12},
    '{1'b0, 12'hFE0, 32'h0,       32'h50,      4'd9},  // R9
    '{1'b0, 12'hFE4, 32'h0,       32'h10,      4'd9},
    '{1'b0, 12'hFE8, 32'h0,       32'h04,      4'd9},
    '{1'b0, 12'hFEC, 32'h0,       32'h00,      4'd9},
    '{1'b0, 12'hFF0, 32'h0,       32'h0D,      4'd9},
    '{1'b0, 12'hFF4, 32'h0,       32'hF0,      4'd9},
    '{1'b0, 12'hFF8, 32'h0,       32'h05,      4'd9},
    '{1'b0, 12'hFFC, 32'h0,       32'hB1,      4'd9},
    '{1'b0, 12'h800, 32'h0,       32'h0,       4'd12}, // R12
    '{1'b1, 12'h000, 32'h0,       32'h0,       4'd2},
    '{1'b0, 12'h00C, 32'h0,       32'hDEADA5C3,4'd11}  // R11 still held
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    txSeen = txStrobe;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 rxReady", {31'b0, rxReady}, 32'd1);
    check("R1 txStrobe", {31'b0, txStrobe}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) busWr(VEC[i].addr, VEC[i].data);
      else begin
        busRd(VEC[i].addr, rd);
        check($sformatf("R%0d vec%0d", VEC[i].req, i), rd, VEC[i].expv);
      end
    end

    // R10 transmit strobe
    busWr(12'h008, 32'h1A5);
    check("R10 strobe", {31'b0, txSeen}, 32'd1);
    check("R10 byte", {24'b0, txByte}, 32'hA5);
    @(negedge clk);
    check("R10 one cycle", {31'b0, txStrobe}, 32'd0);
    busWr(12'h00C, 32'h0);
    check("R10 no strobe other write", {31'b0, txSeen}, 32'd0);

    // R6 R5 R3 R8 receive path
    push(8'h5A);
    check("R6 ready low", {31'b0, rxReady}, 32'd0);
    busRd(12'h004, rd); check("R3 status pending", rd, 32'h50);
    busRd(12'h010, rd); check("R8 istat pending", rd, 32'h03);
    push(8'h33);
    busRd(12'h008, rd); check("R5 R6 pop held", rd, 32'h5A);
    check("R6 ready high", {31'b0, rxReady}, 32'd1);
    busRd(12'h004, rd); check("R4 even parity", rd, 32'h40);
    busRd(12'h008, rd); check("R5 repeat read", rd, 32'h5A);

    // R4 parity follows latched byte only
    push(8'h07);
    busRd(12'h004, rd); check("R4 parity ignores pending", rd, 32'h50);
    busRd(12'h008, rd); check("R5 pop second", rd, 32'h07);
    busRd(12'h004, rd); check("R4 odd parity", rd, 32'h44);

    // R7 interrupt
    busWr(12'h000, 32'h10);
    check("R7 gated idle", {31'b0, irq}, 32'd0);
    push(8'h81);
    check("R7 gated pending", {31'b0, irq}, 32'd1);
    busRd(12'h008, rd); check("R5 pop third", rd, 32'h81);
    check("R7 cleared by pop", {31'b0, irq}, 32'd0);
    busWr(12'h000, 32'h08);
    check("R7 ungated", {31'b0, irq}, 32'd1);
    busWr(12'h000, 32'h00);
    check("R7 off", {31'b0, irq}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule